// File: doc/BRIEF.md
# Address-Masked GPIO Port

This block is an 8-pin general-purpose I/O port behind a small memory-mapped register interface. Software programs three configuration registers: pin direction, digital enable and pull-up. A fourth register holds the data. Each pin drives its output only when its direction bit and its digital-enable bit are both set. A pin is received only when its digital-enable bit is set. Pad levels pass through a synchronizer chain before any read can see them.

Accesses to the data register carry a per-bit mask in address bits [9:2]. Software can set or clear any subset of pins in a single write, with no read-modify-write. The same mask zeroes unselected bits on reads. A clock-gate enable input models the port's bus clock. While it is low, every access is refused and flagged as a bus error.

Top module: `gpio_port`

## Requirements
- R1: A write with byte address in 0x000–0x3FC (addr[11:10]=0, addr[1:0]=0) updates data bit i only when addr[2+i] is 1; every other data bit keeps its value.
- R2: A read in the data window returns 0 in every bit i whose addr[2+i] is 0.
- R3: For a masked-in data bit, a read returns the stored data bit if the direction bit is 1. If the direction bit is 0, it returns the pad level after the two-flop synchronizer. Read data appears on `rdata` in the cycle after the clock edge that samples `rd_en`, and `rdata` is 0 in cycles with no read.
- R4: When direction bit i and enable bit i are both 1, `pin_oe[i]`=1 and `pin_out[i]` equals data bit i. Otherwise `pin_oe[i]`=0 and `pin_out[i]`=0.
- R5: An input pin (direction 0) whose enable bit is 0 reads as 0 whatever its pad level.
- R6: Reset (synchronous, active high) clears direction, enable, pull-up and data, so all pins start as undriven inputs.
- R7: Direction sits at offset 0x400, pull-up at 0x510 and enable at 0x51C. Each is written and read as a full 8-bit value.
- R8: An access (`wr_en` or `rd_en`) while `clk_en`=0 changes no register. It returns `rdata`=0 and sets `bus_err` to 1 in the following cycle only.
- R9: `pin_pu[i]` is 1 exactly when pull-up bit i and enable bit i are 1 and direction bit i is 0. With the pull-up on, a pad that nothing drives reads as 1.
- R10: Offsets outside the data window and the three registers, and unaligned offsets, read 0 and ignore writes. Such accesses raise no bus error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clk_en | input | 1 | Port clock-gate enable; 0 rejects accesses |
| addr | input | 12 | Byte offset of the access |
| wdata | input | 8 | Write data |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| rdata | output | 8 | Read data, one cycle after the read |
| bus_err | output | 1 | Access was rejected, one cycle after the access |
| pin_in | input | 8 | Pad input levels |
| pin_out | output | 8 | Pad output values |
| pin_oe | output | 8 | Pad output enables |
| pin_pu | output | 8 | Pad pull-up enables |

## Verification
The assertions assume `wr_en` and `rd_en` are never high in the same cycle. They also assume `addr` and `wdata` stay valid for the whole cycle in which a strobe is high. The bench drives every access on the falling edge through one write task and one read task that raise a single strobe for one cycle. After any pad or configuration change, the bench waits several cycles before reading, so synchronizer latency never makes a check depend on timing. The pad itself is modelled in the bench: a pin that nothing drives follows `pin_pu`.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

    localparam int PIN_W  = 8;
    localparam int ADDR_W = 12;

    localparam logic [ADDR_W-1:0] OFF_DIR  = 12'h400;
    localparam logic [ADDR_W-1:0] OFF_PULL = 12'h510;
    localparam logic [ADDR_W-1:0] OFF_DEN  = 12'h51C;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_DATA,
        SEL_DIR,
        SEL_PULL,
        SEL_DEN
    } reg_sel_e;

    typedef struct packed {
        logic [PIN_W-1:0] dir;
        logic [PIN_W-1:0] den;
        logic [PIN_W-1:0] pull;
        logic [PIN_W-1:0] data;
    } port_cfg_t;

    function automatic reg_sel_e decode_sel(input logic [ADDR_W-1:0] a);
        reg_sel_e s;
        if (a[1:0] != 2'b00)                    s = SEL_NONE;
        else if (a[ADDR_W-1:10] == '0)          s = SEL_DATA;
        else if (a[ADDR_W-1:2] == OFF_DIR[ADDR_W-1:2])  s = SEL_DIR;
        else if (a[ADDR_W-1:2] == OFF_PULL[ADDR_W-1:2]) s = SEL_PULL;
        else if (a[ADDR_W-1:2] == OFF_DEN[ADDR_W-1:2])  s = SEL_DEN;
        else                                    s = SEL_NONE;
        return s;
    endfunction

    function automatic logic [PIN_W-1:0] addr_mask(input logic [ADDR_W-1:0] a);
        return a[PIN_W+1:2];
    endfunction

endpackage

// File: rtl/gpio_port_sync.sv
module gpio_port_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] chain [STAGES];

    always_ff @(posedge clk) begin
        if (rst) chain[0] <= '0;
        else     chain[0] <= d;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) chain[s] <= '0;
            else     chain[s] <= chain[s-1];
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
    import gpio_port_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_go,
    input  reg_sel_e          sel,
    input  logic [PIN_W-1:0]  mask,
    input  logic [PIN_W-1:0]  wdata,
    output port_cfg_t         cfg
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cfg <= '0;
        end else if (wr_go) begin
            unique case (sel)
                SEL_DATA: cfg.data <= (cfg.data & ~mask) | (wdata & mask);
                SEL_DIR:  cfg.dir  <= wdata;
                SEL_PULL: cfg.pull <= wdata;
                SEL_DEN:  cfg.den  <= wdata;
                default:  ;
            endcase
        end
    end

    // R1: masked-out data bits survive a data-window write
    assert_masked_write_R1: assert property (@(posedge clk) disable iff (rst)
        (wr_go && sel == SEL_DATA) |=>
            ((cfg.data & ~$past(mask)) == ($past(cfg.data) & ~$past(mask))));

    // R10: an unmapped write leaves every register alone
    assert_unmapped_write_R10: assert property (@(posedge clk) disable iff (rst)
        (wr_go && sel == SEL_NONE) |=> $stable(cfg));
endmodule

// File: rtl/gpio_port_rdmux.sv
module gpio_port_rdmux
    import gpio_port_pkg::*;
(
    input  reg_sel_e          sel,
    input  logic [PIN_W-1:0]  mask,
    input  port_cfg_t         cfg,
    input  logic [PIN_W-1:0]  pin_sync,
    output logic [PIN_W-1:0]  rd_val
);
    logic [PIN_W-1:0] pin_view;

    for (genvar i = 0; i < PIN_W; i++) begin : g_bit
        assign pin_view[i] = cfg.dir[i] ? cfg.data[i]
                                        : (cfg.den[i] & pin_sync[i]);
    end

    always_comb begin
        unique case (sel)
            SEL_DATA: rd_val = pin_view & mask;
            SEL_DIR:  rd_val = cfg.dir;
            SEL_PULL: rd_val = cfg.pull;
            SEL_DEN:  rd_val = cfg.den;
            default:  rd_val = '0;
        endcase
    end
endmodule

// File: rtl/gpio_port.sv
module gpio_port
    import gpio_port_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clk_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [PIN_W-1:0]  wdata,
    input  logic              wr_en,
    input  logic              rd_en,
    output logic [PIN_W-1:0]  rdata,
    output logic              bus_err,
    input  logic [PIN_W-1:0]  pin_in,
    output logic [PIN_W-1:0]  pin_out,
    output logic [PIN_W-1:0]  pin_oe,
    output logic [PIN_W-1:0]  pin_pu
);
    reg_sel_e         sel;
    logic [PIN_W-1:0] mask;
    port_cfg_t        cfg;
    logic [PIN_W-1:0] pin_sync;
    logic [PIN_W-1:0] rd_val;
    logic             access;

    assign sel    = decode_sel(addr);
    assign mask   = addr_mask(addr);
    assign access = wr_en | rd_en;

    gpio_port_sync #(.W(PIN_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (pin_in),
        .q   (pin_sync)
    );

    gpio_port_regs u_regs (
        .clk   (clk),
        .rst   (rst),
        .wr_go (wr_en & clk_en),
        .sel   (sel),
        .mask  (mask),
        .wdata (wdata),
        .cfg   (cfg)
    );

    gpio_port_rdmux u_rdmux (
        .sel      (sel),
        .mask     (mask),
        .cfg      (cfg),
        .pin_sync (pin_sync),
        .rd_val   (rd_val)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata   <= '0;
            bus_err <= 1'b0;
        end else begin
            rdata   <= (rd_en && clk_en) ? rd_val : '0;
            bus_err <= access && !clk_en;
        end
    end

    assign pin_oe  = cfg.dir & cfg.den;
    assign pin_out = cfg.data & pin_oe;
    assign pin_pu  = cfg.pull & cfg.den & ~cfg.dir;

    // R2: masked-out bits of a data read come back as zero
    assert_read_mask_R2: assert property (@(posedge clk) disable iff (rst)
        (rd_en && clk_en && sel == SEL_DATA) |=> ((rdata & ~$past(mask)) == '0));

    // R8: a gated access is refused and flagged
    assert_gated_err_R8: assert property (@(posedge clk) disable iff (rst)
        (access && !clk_en) |=> (bus_err && rdata == '0));

    // R8: while gated, configuration cannot move
    assert_gated_hold_R8: assert property (@(posedge clk) disable iff (rst)
        !clk_en |=> $stable(cfg));

    // R8: the error flag follows only a refused access
    assert_err_cause_R8: assert property (@(posedge clk) disable iff (rst)
        bus_err |-> ($past(access) && !$past(clk_en)));

    // R4: a driven pin never lacks its enable bit
    assert_oe_needs_den_R4: assert property (@(posedge clk) disable iff (rst)
        ((pin_oe & ~cfg.den) == '0) && ((pin_out & ~pin_oe) == '0));

    // R9: pull-up never applied to a driven pin
    assert_pu_not_driven_R9: assert property (@(posedge clk) disable iff (rst)
        (pin_pu & pin_oe) == '0);
endmodule

// File: tb/gpio_port_tb.sv
module gpio_port_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        clk_en = 1'b1;
    logic [11:0] addr = '0;
    logic [7:0]  wdata = '0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [7:0]  rdata;
    logic        bus_err;
    logic [7:0]  pin_in;
    logic [7:0]  pin_out;
    logic [7:0]  pin_oe;
    logic [7:0]  pin_pu;
    logic [7:0]  ext_drv = '0;
    logic [7:0]  ext_val = '0;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    // pad model: external driver wins, otherwise the pull-up decides
    assign pin_in = (ext_drv & ext_val) | (~ext_drv & pin_pu);

    gpio_port u_dut (
        .clk(clk), .rst(rst), .clk_en(clk_en), .addr(addr), .wdata(wdata),
        .wr_en(wr_en), .rd_en(rd_en), .rdata(rdata), .bus_err(bus_err),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .pin_pu(pin_pu)
    );

    task automatic check(input string req, input string what,
                         input logic [7:0] got, input logic [7:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_errors++;
            $display("FAIL %s %s: got %02h expected %02h", req, what, got, exp);
        end
    endtask

    task automatic bus_wr(input logic [11:0] a, input logic [7:0] d,
                          output logic err);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        err = bus_err;
    endtask

    task automatic bus_rd(input logic [11:0] a, output logic [7:0] d,
                          output logic err);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        d = rdata;
        err = bus_err;
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [7:0] d; logic e;
        check("R6", "pin_oe after reset", pin_oe, 8'h00);
        check("R6", "pin_out after reset", pin_out, 8'h00);
        check("R3", "rdata idle", rdata, 8'h00);
        bus_rd(12'h400, d, e); check("R6", "dir reset", d, 8'h00);
        bus_rd(12'h51C, d, e); check("R6", "den reset", d, 8'h00);
        bus_rd(12'h510, d, e); check("R6", "pull reset", d, 8'h00);
        bus_rd(12'h3FC, d, e); check("R6", "data reset", d, 8'h00);
    endtask

    task automatic t_offsets();
        logic [7:0] d; logic e;
        bus_wr(12'h400, 8'hA5, e);
        bus_wr(12'h510, 8'h3C, e);
        bus_wr(12'h51C, 8'hFF, e);
        bus_rd(12'h400, d, e); check("R7", "dir readback", d, 8'hA5);
        bus_rd(12'h510, d, e); check("R7", "pull readback", d, 8'h3C);
        bus_rd(12'h51C, d, e); check("R7", "den readback", d, 8'hFF);
    endtask

    task automatic t_masked_write();
        logic [7:0] d; logic e;
        bus_wr(12'h400, 8'hFF, e);
        bus_wr(12'h510, 8'h00, e);
        bus_wr(12'h3FC, 8'h00, e);
        bus_wr(12'h220, 8'hFF, e);   // mask 0x88
        check("R1", "set bits 3,7 only", pin_out, 8'h88);
        check("R4", "all outputs enabled", pin_oe, 8'hFF);
        bus_wr(12'h3FC, 8'hFF, e);
        bus_wr(12'h110, 8'h00, e);   // mask 0x44
        check("R1", "clear bits 2,6 only", pin_out, 8'hBB);
        bus_rd(12'h3FC, d, e); check("R3", "output readback", d, 8'hBB);
    endtask

    task automatic t_masked_read();
        logic [7:0] d; logic e;
        bus_rd(12'h03C, d, e); check("R2", "low-nibble mask", d, 8'h0B);
        bus_rd(12'h000, d, e); check("R2", "empty mask", d, 8'h00);
    endtask

    task automatic t_input();
        logic [7:0] d; logic e;
        ext_drv = 8'hFF; ext_val = 8'hA0;
        bus_wr(12'h400, 8'h0F, e);
        settle();
        bus_rd(12'h3FC, d, e); check("R3", "mixed in/out read", d, 8'hAB);
        check("R4", "oe follows dir", pin_oe, 8'h0F);
        check("R4", "undriven pins out 0", pin_out, 8'h0B);
    endtask

    task automatic t_den_off();
        logic [7:0] d; logic e;
        ext_val = 8'hF0;
        bus_wr(12'h51C, 8'h0F, e);
        settle();
        bus_rd(12'h3FC, d, e); check("R5", "disabled inputs read 0", d, 8'h0B);
        bus_wr(12'h400, 8'hFF, e);
        check("R4", "oe needs enable", pin_oe, 8'h0F);
        check("R4", "out needs enable", pin_out, 8'h0B);
        bus_rd(12'h3FC, d, e); check("R3", "outputs read stored data", d, 8'hBB);
    endtask

    task automatic t_pullup();
        logic [7:0] d; logic e;
        ext_drv = 8'h00;
        bus_wr(12'h400, 8'h00, e);
        bus_wr(12'h51C, 8'hFF, e);
        bus_wr(12'h510, 8'hF0, e);
        settle();
        check("R9", "pull-up on inputs", pin_pu, 8'hF0);
        bus_rd(12'h3FC, d, e); check("R9", "floating pulled pins read 1", d, 8'hF0);
        bus_wr(12'h400, 8'h30, e);
        settle();
        check("R9", "pull-up dropped on outputs", pin_pu, 8'hC0);
        bus_rd(12'h3FC, d, e); check("R3", "outputs and pulled inputs", d, 8'hF0);
    endtask

    task automatic t_gate();
        logic [7:0] d; logic e;
        clk_en = 1'b0;
        bus_wr(12'h400, 8'hFF, e); check("R8", "gated write err", {7'd0, e}, 8'h01);
        bus_wr(12'h3FC, 8'h00, e);
        bus_rd(12'h400, d, e);
        check("R8", "gated read err", {7'd0, e}, 8'h01);
        check("R8", "gated read data", d, 8'h00);
        @(negedge clk);
        check("R8", "err is one cycle", {7'd0, bus_err}, 8'h00);
        clk_en = 1'b1;
        bus_rd(12'h400, d, e);
        check("R8", "dir untouched", d, 8'h30);
        check("R8", "no err when enabled", {7'd0, e}, 8'h00);
        check("R8", "data untouched", pin_out, 8'h30);
    endtask

    task automatic t_unmapped();
        logic [7:0] d; logic e;
        bus_wr(12'h404, 8'hFF, e); check("R10", "unmapped write no err", {7'd0, e}, 8'h00);
        bus_rd(12'h404, d, e);     check("R10", "unmapped read 0", d, 8'h00);
        check("R10", "unmapped read no err", {7'd0, e}, 8'h00);
        bus_wr(12'h402, 8'hFF, e); // unaligned dir alias
        bus_rd(12'h400, d, e);     check("R10", "dir unchanged", d, 8'h30);
        bus_rd(12'hFFC, d, e);     check("R10", "top offset reads 0", d, 8'h00);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_offsets();
        t_masked_write();
        t_masked_read();
        t_input();
        t_den_off();
        t_pullup();
        t_gate();
        t_unmapped();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        #100000;
        if (!done) begin
            done = 1;
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end
endmodule